// File: doc/BRIEF.md
# SD Command Line Framer

This block is the host-side engine for the single-wire command line of an SD-style bus. When a request is accepted, it builds a 48-bit command token from a 6-bit command index and a 32-bit argument. It appends a 7-bit CRC and shifts the token out one bit per clock, most significant bit first. Between tokens the line stays released and high.

After the token the framer does one of three things, chosen per request:
- It finishes at once, for a command that has no answer.
- It waits for a short 48-bit reply.
- It waits for a long 136-bit reply.

While waiting, the first low bit sampled on the input line counts as the reply's start bit. If no start bit arrives within a fixed window, the transaction ends with a timeout. A captured reply is checked for a correct end bit. A short reply also has its CRC checked. The result is reported in a one-cycle done pulse, with a payload and error flags that stay valid until the next request.

Sequencing of commands, card state tracking, data-line traffic and clock-rate control belong to the surrounding logic.

Top module: `sdcmd_framer`

## Requirements
- R1: After reset, and whenever idle, `cmd_ready` is 1, `cmd_oe` is 0, `cmd_out` is 1 and `rsp_done` is 0.
- R2: A request is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. From the next cycle, `cmd_oe` is high for exactly 48 cycles. During those cycles `cmd_out` carries, most significant bit first: a 0 start bit, a 1 transmitter bit, the 6-bit index, the 32-bit argument, a 7-bit CRC and a 1 end bit.
- R3: The token CRC is the remainder of the first 40 token bits under x^7 + x^3 + 1, starting from zero. It occupies token bits 7..1.
- R4: `cmd_valid` and the request inputs have no effect while a transaction is in progress. The token on the line is unchanged.
- R5: With `rsp_expect` = 0, `rsp_done` pulses in the cycle after the end bit, with all three error flags 0.
- R6: With `rsp_expect` = 1 and `rsp_long` = 0, the first 0 sampled after the line is released is the start of a 48-bit reply. `rsp_done` rises in the cycle after the reply's last bit is sampled. `rsp_data[37:32]` holds reply bits 45..40, `rsp_data[31:0]` holds reply bits 39..8, and the upper bits are 0.
- R7: For a 48-bit reply, `rsp_crc_err` is 1 exactly when reply bits 7..1 differ from the CRC of reply bits 47..8.
- R8: With `rsp_long` = 1, the reply is 136 bits long. `rsp_data` holds its last 128 bits, with the final bit in `rsp_data[0]`. `rsp_crc_err` stays 0.
- R9: `rsp_end_err` is 1 exactly when the last sampled reply bit is 0, for either reply length.
- R10: If no 0 is sampled in the 64 cycles after the line is released, `rsp_done` pulses in the cycle after the 64th with `rsp_timeout` = 1 and the other flags 0. A start bit in the 64th cycle is accepted.
- R11: `rsp_done` lasts one cycle and coincides with `cmd_ready` returning to 1. The flags and `rsp_data` hold until the next acceptance, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request strobe |
| cmd_ready | output | 1 | Framer idle, request can be accepted |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_expect | input | 1 | 1: a reply follows the command |
| rsp_long | input | 1 | 1: reply is 136 bits, 0: reply is 48 bits |
| cmd_out | output | 1 | Serial command bit, high when not driving |
| cmd_oe | output | 1 | Output enable for the command line |
| cmd_in | input | 1 | Sampled command line |
| rsp_done | output | 1 | One-cycle end-of-transaction pulse |
| rsp_timeout | output | 1 | No start bit within the window |
| rsp_crc_err | output | 1 | Short reply CRC mismatch |
| rsp_end_err | output | 1 | Reply end bit was 0 |
| rsp_data | output | 128 | Captured reply payload |

## Verification
On every cycle, the bound checker enforces the line behaviour:
- the idle line level and the 48-cycle drive window;
- the start, transmitter and end bits at their positions;
- the single-cycle done pulse and its alignment with ready;
- flags holding while idle;
- that a timeout is reported exactly 64 released cycles after the token.

Only the bench scenarios can show data correctness: the CRC value, the index and argument bits in between, the captured payload of both reply lengths, and the CRC and end-bit verdicts. The same goes for the exact boundary between a start bit in the last window cycle and a timeout, and for requests made while busy being ignored.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

   localparam int CRC_W = 7;
   localparam logic [CRC_W-1:0] CRC_TAPS = 7'h09;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_HUNT = 2'd1,
      PH_TAKE = 2'd2
   } rx_phase_e;

   // one serial step of the x^7 + x^3 + 1 remainder
   function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
      logic fb;
      fb = b ^ c[CRC_W-1];
      return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_TAPS : '0);
   endfunction

endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7
   import sdcmd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             d,
   output logic [CRC_W-1:0] crc
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc <= '0;
      end else if (clr) begin
         crc <= '0;
      end else if (en) begin
         crc <= crc_step(crc, d);
      end
   end

endmodule

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
   import sdcmd_pkg::*;
#(
   parameter int IDX_W = 6,
   parameter int ARG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] idx,
   input  logic [ARG_W-1:0] arg,
   output logic             line,
   output logic             oe,
   output logic             last
);

   localparam int BODY_W  = 2 + IDX_W + ARG_W;
   localparam int TOK_LEN = BODY_W + CRC_W + 1;
   localparam int CNT_W   = $clog2(TOK_LEN);

   function automatic logic [CRC_W-1:0] body_crc(input logic [BODY_W-1:0] b);
      logic [CRC_W-1:0] c;
      c = '0;
      for (int i = BODY_W - 1; i >= 0; i--) begin
         c = crc_step(c, b[i]);
      end
      return c;
   endfunction

   logic [BODY_W-1:0]  body;
   logic [TOK_LEN-1:0] sr;
   logic [CNT_W-1:0]   cnt;
   logic               active;

   assign body = {1'b0, 1'b1, idx, arg};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr     <= '1;
         cnt    <= '0;
         active <= 1'b0;
      end else if (load) begin
         sr     <= {body, body_crc(body), 1'b1};
         cnt    <= '0;
         active <= 1'b1;
      end else if (active) begin
         sr  <= {sr[TOK_LEN-2:0], 1'b1};
         cnt <= cnt + 1'b1;
         if (cnt == CNT_W'(TOK_LEN - 1)) begin
            active <= 1'b0;
         end
      end
   end

   assign line = active ? sr[TOK_LEN-1] : 1'b1;
   assign oe   = active;
   assign last = active && (cnt == CNT_W'(TOK_LEN - 1));

endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
   import sdcmd_pkg::*;
#(
   parameter int BODY_W  = 40,
   parameter int PAY_W   = 128,
   parameter int TMO_CYC = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             arm_long,
   input  logic             line,
   output logic             fin,
   output logic             fin_tmo,
   output logic             fin_crc_bad,
   output logic             fin_end_bad,
   output logic [PAY_W-1:0] payload
);

   localparam int SHORT_LEN = BODY_W + CRC_W + 1;
   localparam int LONG_LEN  = PAY_W + 8;
   localparam int SR_W      = PAY_W - 1;
   localparam int BC_W      = $clog2(LONG_LEN);
   localparam int WC_W      = $clog2(TMO_CYC);
   localparam int SPAY_W    = BODY_W - 2;

   rx_phase_e        ph;
   logic             long_r;
   logic [WC_W-1:0]  wcnt;
   logic [BC_W-1:0]  bcnt;
   logic [SR_W-1:0]  sr;
   logic [PAY_W-1:0] nxt;
   logic [CRC_W-1:0] crc;
   logic             hunt_hit, hunt_miss, take_last, crc_en;

   assign nxt       = {sr, line};
   assign hunt_hit  = (ph == PH_HUNT) && !line;
   assign hunt_miss = (ph == PH_HUNT) && line && (wcnt == WC_W'(TMO_CYC - 1));
   assign take_last = (ph == PH_TAKE) &&
                      (bcnt == (long_r ? BC_W'(LONG_LEN - 1) : BC_W'(SHORT_LEN - 1)));
   assign crc_en    = hunt_hit || ((ph == PH_TAKE) && (bcnt < BC_W'(BODY_W)));

   sdcmd_crc7 u_crc (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (arm),
      .en   (crc_en),
      .d    (line),
      .crc  (crc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         long_r <= 1'b0;
         wcnt   <= '0;
         bcnt   <= '0;
         sr     <= '1;
      end else begin
         case (ph)
            PH_IDLE: begin
               if (arm) begin
                  ph     <= PH_HUNT;
                  long_r <= arm_long;
                  wcnt   <= '0;
               end
            end
            PH_HUNT: begin
               if (hunt_hit) begin
                  ph   <= PH_TAKE;
                  bcnt <= BC_W'(1);
                  sr   <= nxt[SR_W-1:0];
               end else if (hunt_miss) begin
                  ph <= PH_IDLE;
               end else begin
                  wcnt <= wcnt + 1'b1;
               end
            end
            PH_TAKE: begin
               sr   <= nxt[SR_W-1:0];
               bcnt <= bcnt + 1'b1;
               if (take_last) begin
                  ph <= PH_IDLE;
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign fin         = hunt_miss || take_last;
   assign fin_tmo     = hunt_miss;
   assign fin_crc_bad = take_last && !long_r && (crc != nxt[CRC_W:1]);
   assign fin_end_bad = take_last && !line;
   assign payload     = long_r ? nxt : PAY_W'(nxt[SHORT_LEN-3:8]);

   // keep the short payload width consistent with the body layout
   if (SPAY_W != SHORT_LEN - 10) begin : g_bad_layout
      $error("sdcmd_rx: inconsistent short reply layout");
   end

endmodule

// File: rtl/sdcmd_framer.sv
module sdcmd_framer
   import sdcmd_pkg::*;
#(
   parameter int IDX_W      = 6,
   parameter int ARG_W      = 32,
   parameter int LONG_PAY_W = 128,
   parameter int TMO_CYC    = 64,
   parameter int IN_FLOPS   = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   output logic                  cmd_ready,
   input  logic [IDX_W-1:0]      cmd_index,
   input  logic [ARG_W-1:0]      cmd_arg,
   input  logic                  rsp_expect,
   input  logic                  rsp_long,
   output logic                  cmd_out,
   output logic                  cmd_oe,
   input  logic                  cmd_in,
   output logic                  rsp_done,
   output logic                  rsp_timeout,
   output logic                  rsp_crc_err,
   output logic                  rsp_end_err,
   output logic [LONG_PAY_W-1:0] rsp_data
);

   localparam int BODY_W  = 2 + IDX_W + ARG_W;
   localparam int TOK_LEN = BODY_W + CRC_W + 1;

   if (LONG_PAY_W < TOK_LEN) begin : g_bad_pay
      $error("sdcmd_framer: long payload narrower than a short token");
   end
   if (TMO_CYC < 2) begin : g_bad_tmo
      $error("sdcmd_framer: timeout window must be at least 2 cycles");
   end
   if (IN_FLOPS < 0) begin : g_bad_flops
      $error("sdcmd_framer: negative input stage count");
   end

   logic line_s;

   if (IN_FLOPS == 0) begin : g_in_direct
      assign line_s = cmd_in;
   end else begin : g_in_staged
      logic [IN_FLOPS-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg <= '1;
         end else begin
            stg[0] <= cmd_in;
            for (int k = 1; k < IN_FLOPS; k++) begin
               stg[k] <= stg[k-1];
            end
         end
      end
      assign line_s = stg[IN_FLOPS-1];
   end

   logic                  busy, exp_r, long_r;
   logic                  accept, tx_last, arm;
   logic                  fin, fin_tmo, fin_crc_bad, fin_end_bad;
   logic [LONG_PAY_W-1:0] payload;

   assign accept    = cmd_valid && !busy;
   assign cmd_ready = !busy;
   assign arm       = tx_last && exp_r;

   sdcmd_tx #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_tx (
      .clk  (clk),
      .rst_n(rst_n),
      .load (accept),
      .idx  (cmd_index),
      .arg  (cmd_arg),
      .line (cmd_out),
      .oe   (cmd_oe),
      .last (tx_last)
   );

   sdcmd_rx #(.BODY_W(BODY_W), .PAY_W(LONG_PAY_W), .TMO_CYC(TMO_CYC)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (arm),
      .arm_long   (long_r),
      .line       (line_s),
      .fin        (fin),
      .fin_tmo    (fin_tmo),
      .fin_crc_bad(fin_crc_bad),
      .fin_end_bad(fin_end_bad),
      .payload    (payload)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy        <= 1'b0;
         exp_r       <= 1'b0;
         long_r      <= 1'b0;
         rsp_done    <= 1'b0;
         rsp_timeout <= 1'b0;
         rsp_crc_err <= 1'b0;
         rsp_end_err <= 1'b0;
         rsp_data    <= '0;
      end else begin
         rsp_done <= 1'b0;
         if (accept) begin
            busy        <= 1'b1;
            exp_r       <= rsp_expect;
            long_r      <= rsp_long;
            rsp_timeout <= 1'b0;
            rsp_crc_err <= 1'b0;
            rsp_end_err <= 1'b0;
            rsp_data    <= '0;
         end
         if (tx_last && !exp_r) begin
            busy     <= 1'b0;
            rsp_done <= 1'b1;
         end
         if (fin) begin
            busy        <= 1'b0;
            rsp_done    <= 1'b1;
            rsp_timeout <= fin_tmo;
            rsp_crc_err <= fin_crc_bad;
            rsp_end_err <= fin_end_bad;
            rsp_data    <= fin_tmo ? '0 : payload;
         end
      end
   end

endmodule

// File: rtl/sdcmd_framer_chk.sv
module sdcmd_framer_chk #(
   parameter int TOK_LEN = 48,
   parameter int TMO_CYC = 64
) (
   input logic clk,
   input logic rst_n,
   input logic cmd_valid,
   input logic cmd_ready,
   input logic cmd_out,
   input logic cmd_oe,
   input logic rsp_done,
   input logic rsp_timeout,
   input logic rsp_crc_err,
   input logic rsp_end_err
);

   localparam int RUN_W = $clog2(TOK_LEN + 2) + 1;
   localparam int QC_W  = $clog2(TMO_CYC + 2) + 1;

   logic [RUN_W-1:0] oe_run;
   logic [QC_W-1:0]  quiet_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_run    <= '0;
         quiet_cnt <= '0;
      end else begin
         if (!cmd_oe) oe_run <= '0;
         else if (oe_run != '1) oe_run <= oe_run + 1'b1;
         if (cmd_oe || cmd_ready) quiet_cnt <= '0;
         else if (quiet_cnt != '1) quiet_cnt <= quiet_cnt + 1'b1;
      end
   end

   p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (cmd_out && !cmd_oe));

   p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_oe) |-> !cmd_out);

   p_host_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_oe && oe_run == RUN_W'(1)) |-> cmd_out);

   p_end_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_oe && oe_run == RUN_W'(TOK_LEN - 1)) |-> cmd_out);

   p_tok_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_oe && oe_run == RUN_W'(TOK_LEN - 1)) |=> !cmd_oe);

   p_tok_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_oe) |-> ($past(oe_run) == RUN_W'(TOK_LEN - 1)));

   p_busy_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_oe |-> !cmd_ready);

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   p_done_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> cmd_ready);

   p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ready && !cmd_valid) |=> $stable({rsp_timeout, rsp_crc_err, rsp_end_err}));

   p_tmo_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_timeout |-> (!rsp_crc_err && !rsp_end_err));

   p_tmo_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && rsp_timeout) |-> (quiet_cnt == QC_W'(TMO_CYC)));

endmodule

bind sdcmd_framer sdcmd_framer_chk #(.TOK_LEN(TOK_LEN), .TMO_CYC(TMO_CYC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_ready  (cmd_ready),
   .cmd_out    (cmd_out),
   .cmd_oe     (cmd_oe),
   .rsp_done   (rsp_done),
   .rsp_timeout(rsp_timeout),
   .rsp_crc_err(rsp_crc_err),
   .rsp_end_err(rsp_end_err)
);

// File: tb/sdcmd_framer_tb_top.sv
module sdcmd_framer_tb_top;

   localparam int TMO = 64;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0;
   logic         cmd_ready;
   logic [5:0]   cmd_index = '0;
   logic [31:0]  cmd_arg = '0;
   logic         rsp_expect = 1'b0;
   logic         rsp_long = 1'b0;
   logic         cmd_out, cmd_oe;
   logic         cmd_in = 1'b1;
   logic         rsp_done, rsp_timeout, rsp_crc_err, rsp_end_err;
   logic [127:0] rsp_data;

   int n_checks = 0;
   int n_errors = 0;

   always #4 clk = ~clk;

   sdcmd_framer dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_ready  (cmd_ready),
      .cmd_index  (cmd_index),
      .cmd_arg    (cmd_arg),
      .rsp_expect (rsp_expect),
      .rsp_long   (rsp_long),
      .cmd_out    (cmd_out),
      .cmd_oe     (cmd_oe),
      .cmd_in     (cmd_in),
      .rsp_done   (rsp_done),
      .rsp_timeout(rsp_timeout),
      .rsp_crc_err(rsp_crc_err),
      .rsp_end_err(rsp_end_err),
      .rsp_data   (rsp_data)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // long-hand polynomial division of the 40 body bits by 0x89
   function automatic logic [6:0] ref_crc(input logic [39:0] body);
      logic [46:0] v;
      v = {body, 7'b0};
      for (int i = 46; i >= 7; i--) begin
         if (v[i]) v[i -: 8] = v[i -: 8] ^ 8'h89;
      end
      return v[6:0];
   endfunction

   task automatic do_cmd(input logic [5:0] idx, input logic [31:0] arg,
                         input bit exp, input bit lng, input int dly,
                         input bit bad_crc, input bit bad_end, input bit poke,
                         input logic [31:0] rarg, input logic [127:0] lpay);
      logic [47:0]  tok, got;
      logic [135:0] rbits;
      logic [127:0] exp_data;
      logic [6:0]   rcrc;
      int           rlen;
      bit           oe_ok;
      bit           rdy_ok;
      tok    = {1'b0, 1'b1, idx, arg, ref_crc({1'b0, 1'b1, idx, arg}), 1'b1};
      got    = '0;
      oe_ok  = 1'b1;
      rdy_ok = 1'b1;
      @(negedge clk);
      check(cmd_ready == 1'b1, "R11", "ready before request", 128'(cmd_ready), 128'd1);
      cmd_valid  = 1'b1;
      cmd_index  = idx;
      cmd_arg    = arg;
      rsp_expect = exp;
      rsp_long   = lng;
      @(negedge clk);
      cmd_valid = 1'b0;
      check({rsp_timeout, rsp_crc_err, rsp_end_err} == 3'b000 && rsp_data == '0,
            "R11", "flags cleared on accept", {125'd0, rsp_timeout, rsp_crc_err, rsp_end_err}, '0);
      for (int i = 0; i < 48; i++) begin
         if (i > 0) @(negedge clk);
         got[47-i] = cmd_out;
         if (!cmd_oe) oe_ok = 1'b0;
         if (cmd_ready) rdy_ok = 1'b0;
         if (poke && i == 5) begin
            cmd_valid = 1'b1;
            cmd_index = ~idx;
            cmd_arg   = ~arg;
         end
         if (poke && i == 7) cmd_valid = 1'b0;
      end
      check(oe_ok, "R2", "drive enable held 48 cycles", 128'(oe_ok), 128'd1);
      check(got[47:8] == tok[47:8] && got[0] == 1'b1, "R2", "token fields",
            128'(got), 128'(tok));
      check(got[7:1] == tok[7:1], "R3", "token crc", 128'(got[7:1]), 128'(tok[7:1]));
      if (poke) begin
         check(got == tok && rdy_ok, "R4", "request while busy ignored", 128'(got), 128'(tok));
      end
      @(negedge clk);
      check(cmd_oe == 1'b0, "R2", "line released after 48 bits", 128'(cmd_oe), 128'd0);
      if (!exp) begin
         check(rsp_done && {rsp_timeout, rsp_crc_err, rsp_end_err} == 3'b000, "R5",
               "done without reply", {124'd0, rsp_done, rsp_timeout, rsp_crc_err, rsp_end_err},
               128'd8);
         check(cmd_ready == 1'b1, "R11", "ready with done", 128'(cmd_ready), 128'd1);
         @(negedge clk);
         check(rsp_done == 1'b0, "R11", "done one cycle", 128'(rsp_done), 128'd0);
         return;
      end
      if (dly >= TMO) begin
         repeat (TMO - 1) @(negedge clk);
         check(rsp_done == 1'b0, "R10", "no early timeout", 128'(rsp_done), 128'd0);
         @(negedge clk);
         check(rsp_done && rsp_timeout && !rsp_crc_err && !rsp_end_err, "R10", "timeout flags",
               {124'd0, rsp_done, rsp_timeout, rsp_crc_err, rsp_end_err}, 128'hC);
         @(negedge clk);
         check(rsp_done == 1'b0 && rsp_timeout, "R11", "timeout flag held",
               {126'd0, rsp_done, rsp_timeout}, 128'd1);
         return;
      end
      if (lng) begin
         rlen     = 136;
         rbits    = {2'b00, 6'h3F, lpay[127:1], ~bad_end};
         exp_data = {lpay[127:1], ~bad_end};
      end else begin
         rlen     = 48;
         rcrc     = ref_crc({2'b00, idx, rarg}) ^ {6'd0, bad_crc};
         rbits    = {88'd0, 2'b00, idx, rarg, rcrc, ~bad_end};
         exp_data = {90'd0, idx, rarg};
      end
      repeat (dly) @(negedge clk);
      for (int i = 0; i < rlen; i++) begin
         if (i == rlen - 1)
            check(rsp_done == 1'b0, lng ? "R8" : "R6", "no early done", 128'(rsp_done), 128'd0);
         cmd_in = rbits[rlen-1-i];
         @(negedge clk);
      end
      cmd_in = 1'b1;
      check(rsp_done == 1'b1 && cmd_ready, lng ? "R8" : "R6", "done after last bit",
            {126'd0, rsp_done, cmd_ready}, 128'd3);
      check(rsp_data == exp_data, lng ? "R8" : "R6", "payload", rsp_data, exp_data);
      if (lng)
         check(rsp_crc_err == 1'b0, "R8", "no crc check on long", 128'(rsp_crc_err), 128'd0);
      else
         check(rsp_crc_err == bad_crc, "R7", "crc verdict", 128'(rsp_crc_err), 128'(bad_crc));
      check(rsp_end_err == bad_end, "R9", "end bit verdict", 128'(rsp_end_err), 128'(bad_end));
      check(rsp_timeout == 1'b0, "R10", "no timeout on reply", 128'(rsp_timeout), 128'd0);
      @(negedge clk);
      check(rsp_done == 1'b0 && rsp_data == exp_data, "R11", "data held after done",
            rsp_data, exp_data);
   endtask

   initial begin
      #(8 * 150000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd7741));
      repeat (3) @(negedge clk);
      check(cmd_ready && !cmd_oe && cmd_out && !rsp_done, "R1", "reset idle state",
            {124'd0, cmd_ready, cmd_oe, cmd_out, rsp_done}, 128'hA);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(cmd_ready && !cmd_oe && cmd_out, "R1", "idle after reset",
            {125'd0, cmd_ready, cmd_oe, cmd_out}, 128'h5);

      // directed corners
      do_cmd(6'd0, 32'h0, 0, 0, 0, 0, 0, 0, 32'h0, '0);                         // R5
      do_cmd(6'd17, 32'h0000_0200, 1, 0, 0, 0, 0, 0, 32'h0000_0900, '0);       // R6
      do_cmd(6'd55, 32'hFFFF_FFFF, 1, 0, TMO - 1, 0, 0, 0, 32'h1234_5678, '0);  // R10 last slot
      do_cmd(6'd8, 32'h0000_01AA, 1, 0, TMO, 0, 0, 0, 32'h0, '0);               // R10 timeout
      do_cmd(6'd13, 32'hA5A5_5A5A, 1, 0, 2, 1, 0, 0, 32'hDEAD_BEEF, '0);        // R7
      repeat (5) @(negedge clk);
      check(rsp_crc_err == 1'b1, "R11", "crc flag held while idle", 128'(rsp_crc_err), 128'd1);
      do_cmd(6'd24, 32'h0BAD_F00D, 1, 0, 1, 0, 1, 0, 32'h0000_0001, '0);        // R9 short
      do_cmd(6'd2, 32'h0, 1, 1, 3, 1, 0, 0, 32'h0,
             128'hFEDC_BA98_7654_3210_0123_4567_89AB_CDEF);                    // R8
      do_cmd(6'd9, 32'h0001_0000, 1, 1, 0, 0, 1, 0, 32'h0, '1);                 // R9 long
      do_cmd(6'd63, 32'h8000_0001, 0, 0, 0, 0, 0, 1, 32'h0, '0);                // R4
      do_cmd(6'd41, 32'h40FF_8000, 1, 0, 4, 0, 0, 1, 32'hC0DE_0042, '0);        // R4 with reply

      // constrained random mix
      for (int n = 0; n < 24; n++) begin
         logic [5:0]   ridx;
         logic [31:0]  rarg_c, rarg_r;
         logic [127:0] rp;
         bit           e, l, bc, be;
         int           d;
         ridx   = 6'($urandom);
         rarg_c = $urandom;
         rarg_r = $urandom;
         rp     = {$urandom, $urandom, $urandom, $urandom};
         e      = ($urandom % 4) != 0;
         l      = ($urandom % 3) == 0;
         d      = (($urandom % 8) == 0) ? TMO : int'($urandom % 12);
         bc     = ($urandom % 4) == 0;
         be     = ($urandom % 6) == 0;
         do_cmd(ridx, rarg_c, e, l, d, bc, be, 0, rarg_r, rp);
      end

      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule